// File: doc/BRIEF.md
# Core module system control register file

This block is the control and status register file of a processor core module. It sits on a simple 32-bit register bus. Each access is one request cycle carrying a byte address, and write data is taken as a whole word. Read data comes back one cycle after the request, marked by a valid strobe.

Software uses it for several jobs. It reads fixed identity words. It programs two oscillator words, which are only writable after a 16-bit unlock key has been stored. It drives a status LED and the boot memory remap select, and it requests a system reset. It keeps two flag words that have separate set and clear addresses. It reads a free-running reference counter that advances once for every pulse on a 24 MHz tick input. It reads a small memory-module descriptor, and it raises a local software interrupt. The interrupt goes out on a normal line and on a fast line, each through its own enable mask.

Top module: `cm_sysctl_regs`

## Requirements
- R1: Reads of word index 0 return 0x411A3001, index 4 returns 0x00100000 and index 1 returns 0. Any index without a register returns 0, as do the clear addresses 13, 15, 19, 21 and 27. Unaligned addresses (addr bits 1:0 not zero) and byte addresses at or above 0x200 return 0 and ignore writes.
- R2: A write to index 5 (lock) keeps only bits 15:0. When the kept value is 0xA05F, reads return 0x0001A05F. Otherwise reads return the kept value.
- R3: Writes to index 2 (oscillator) and index 7 (auxiliary oscillator) update the word only while the kept lock value equals 0xA05F. At any other time they are dropped.
- R4: A write to index 3 (control) keeps only bit 0 (LED, driven on led_o) and bit 2 (remap, driven on remap_o). Reads return the kept bits, and bit 3 always reads 0.
- R5: A control write with bit 3 set drives reset_req_o high for exactly one cycle. That cycle is the one after the write.
- R6: Index 12 ORs the written value into the flag word and index 13 clears the bits written as 1. Reads of index 12 return the flag word. Indexes 14 and 15 do the same for a second flag word, which reads at index 14.
- R7: Index 10 returns a 32-bit counter. The counter is 0 after reset and increases by one in each cycle where tick_i is high. Writes to index 10 leave the counter unchanged.
- R8: Byte address 0x100+4k (k = 0..31) returns descriptor byte k in bits 7:0. Byte 0 is 0x80 and byte 2 is 0x04. Byte 31 is the density code: 0x40 for MEM_MB of 256 or more, 0x20 for 128 or more, 0x10 for 64 or more, 0x04 for 32 or more, and 0x02 otherwise. All other bytes are 0. Addresses 0x180 to 0x1FF return 0.
- R9: After reset the following values hold. Oscillator is 0x01000048, auxiliary oscillator is 0x0007FEFF, init (index 9) is 0x00000112, and lock, control and both flag words are 0. The SDRAM word (index 8) is 0x00011122 ORed with a size code: 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more. With the default of 128 it reads 0x0001112E. Indexes 8 and 9 take any written value.
- R10: The interrupt source is a single software bit. Writing 1 in bit 0 to index 20 sets it, and writing 1 in bit 0 to index 21 clears it. Index 20 reads the bit and indexes 17 and 25 read it raw. Indexes 18 and 26 OR into the normal and fast enable words, and indexes 19 and 27 clear bits in them. Reads of 18 and 26 return those enable words. Indexes 16 and 24 return the source ANDed with bit 0 of the matching enable. irq_o and fiq_o are high exactly when those two values are nonzero.
- R11: A read request produces rvalid_o high with its data on rdata_o in the following cycle. A write request produces no rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 24 MHz reference tick enable |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| led_o | output | 1 | Status LED |
| remap_o | output | 1 | Boot memory remap select (1 disables the flash at zero) |
| reset_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Normal interrupt |
| fiq_o | output | 1 | Fast interrupt |

## Verification
The assertions watch several rules on every cycle: the oscillator words hold whenever the lock is not at its key value, the reset request never lasts two cycles, and a clear write empties the bits it names. They also check that the counter either holds or steps by one depending on the tick, that a soft-clear drops both interrupt lines, and that each read is answered one cycle later. The bench scenarios cover the parts a per-cycle property cannot pin to a value: the fixed identity and reset words, the exact lock readback, the descriptor contents at its edges, and the SDRAM size code. They also show that writes to protected or read-only words leave the readback unchanged.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;
  localparam int unsigned DW = 32;
  typedef logic [5:0] widx_t;

  localparam widx_t W_ID       = 6'd0;
  localparam widx_t W_PROC     = 6'd1;
  localparam widx_t W_OSC      = 6'd2;
  localparam widx_t W_CTRL     = 6'd3;
  localparam widx_t W_STAT     = 6'd4;
  localparam widx_t W_LOCK     = 6'd5;
  localparam widx_t W_AUX      = 6'd7;
  localparam widx_t W_SDRAM    = 6'd8;
  localparam widx_t W_INIT     = 6'd9;
  localparam widx_t W_REFCNT   = 6'd10;
  localparam widx_t W_FLG_SET  = 6'd12;
  localparam widx_t W_FLG_CLR  = 6'd13;
  localparam widx_t W_NVF_SET  = 6'd14;
  localparam widx_t W_NVF_CLR  = 6'd15;
  localparam widx_t W_IRQ_STAT = 6'd16;
  localparam widx_t W_IRQ_RAW  = 6'd17;
  localparam widx_t W_IRQ_ENS  = 6'd18;
  localparam widx_t W_IRQ_ENC  = 6'd19;
  localparam widx_t W_SOFT_SET = 6'd20;
  localparam widx_t W_SOFT_CLR = 6'd21;
  localparam widx_t W_FIQ_STAT = 6'd24;
  localparam widx_t W_FIQ_RAW  = 6'd25;
  localparam widx_t W_FIQ_ENS  = 6'd26;
  localparam widx_t W_FIQ_ENC  = 6'd27;

  localparam logic [DW-1:0] ID_VAL     = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_VAL   = 32'h0010_0000;
  localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;
  localparam logic [DW-1:0] OSC_RST    = 32'h0100_0048;
  localparam logic [DW-1:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [DW-1:0] INIT_RST   = 32'h0000_0112;
  localparam logic [DW-1:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [DW-1:0] CTRL_KEEP  = 32'h0000_0005;
  localparam int unsigned   CTRL_RST_BIT = 3;

  function automatic logic [DW-1:0] sdram_rst(int unsigned mb);
    logic [DW-1:0] code;
    if (mb >= 256)      code = 32'h10;
    else if (mb >= 128) code = 32'h0C;
    else if (mb >= 64)  code = 32'h08;
    else if (mb >= 32)  code = 32'h04;
    else                code = 32'h00;
    return SDRAM_BASE | code;
  endfunction

  function automatic logic [7:0] density_byte(int unsigned mb);
    if (mb >= 256)      return 8'h40;
    else if (mb >= 128) return 8'h20;
    else if (mb >= 64)  return 8'h10;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h02;
  endfunction

  function automatic logic [7:0] desc_byte(logic [4:0] k, int unsigned mb);
    case (k)
      5'd0:    return 8'h80;
      5'd2:    return 8'h04;
      5'd31:   return density_byte(mb);
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cm_key_regs.sv
module cm_key_regs
  import cm_sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lock_i,
  input  logic          wr_osc_i,
  input  logic          wr_aux_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lock_rd_o,
  output logic [DW-1:0] osc_o,
  output logic [DW-1:0] aux_o
);
  logic [15:0] lock_q;
  logic        open_w;

  assign open_w = (lock_q == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      osc_o  <= OSC_RST;
      aux_o  <= AUX_RST;
    end else begin
      if (wr_lock_i)           lock_q <= wdata_i[15:0];
      if (wr_osc_i && open_w)  osc_o  <= wdata_i;
      if (wr_aux_i && open_w)  aux_o  <= wdata_i;
    end
  end

  assign lock_rd_o = open_w ? {15'd0, 1'b1, lock_q} : {16'd0, lock_q};

  AST_OSC_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_rd_o[16] == 1'b0) |=> $stable(osc_o) && $stable(aux_o)); // R3
  AST_LOCK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_rd_o[16] |-> (lock_rd_o[15:0] == UNLOCK_KEY)); // R2
endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end

  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(data_i)) == '0)); // R6
  AST_SET_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(data_i)) == $past(data_i))); // R6
endmodule

// File: rtl/cm_ref_counter.sv
module cm_ref_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o)); // R7
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_o == $past(cnt_o) + 1'b1)); // R7
endmodule

// File: rtl/cm_irq_group.sv
module cm_irq_group
  import cm_sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_set_i,
  input  logic          soft_clr_i,
  input  logic          irq_ens_i,
  input  logic          irq_enc_i,
  input  logic          fiq_ens_i,
  input  logic          fiq_enc_i,
  input  logic [DW-1:0] wdata_i,
  output logic          level_o,
  output logic [DW-1:0] irq_en_o,
  output logic [DW-1:0] fiq_en_o,
  output logic          irq_o,
  output logic          fiq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= 1'b0;
      irq_en_o <= '0;
      fiq_en_o <= '0;
    end else begin
      if (soft_set_i && wdata_i[0])      level_o <= 1'b1;
      else if (soft_clr_i && wdata_i[0]) level_o <= 1'b0;
      if (irq_ens_i)      irq_en_o <= irq_en_o | wdata_i;
      else if (irq_enc_i) irq_en_o <= irq_en_o & ~wdata_i;
      if (fiq_ens_i)      fiq_en_o <= fiq_en_o | wdata_i;
      else if (fiq_enc_i) fiq_en_o <= fiq_en_o & ~wdata_i;
    end
  end

  assign irq_o = level_o & irq_en_o[0];
  assign fiq_o = level_o & fiq_en_o[0];

  AST_SOFT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_clr_i && wdata_i[0]) |=> (!irq_o && !fiq_o)); // R10
  AST_SOFT_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_set_i && wdata_i[0]) |=> level_o); // R10
endmodule

// File: rtl/cm_sysctl_regs.sv
module cm_sysctl_regs
  import cm_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MEM_MB = 128,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              led_o,
  output logic              remap_o,
  output logic              reset_req_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned NFLAG = 2;
  localparam logic [DW-1:0] SDRAM_RST = sdram_rst(MEM_MB);

  logic  aligned, in_regs, in_win, win_lo, wr;
  widx_t widx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_regs = aligned && (addr_i[ADDR_W-1:8] == '0);
  assign in_win  = aligned && (addr_i[ADDR_W-1:8] == 1);
  assign win_lo  = in_win && !addr_i[7];
  assign widx    = addr_i[7:2];
  assign wr      = req_i && we_i && in_regs;

  function automatic logic hit(widx_t idx);
    return wr && (widx == idx);
  endfunction

  // keyed oscillator words
  logic [DW-1:0] lock_rd, osc_q, aux_q;
  cm_key_regs u_key (
    .clk_i, .rst_ni,
    .wr_lock_i (hit(W_LOCK)),
    .wr_osc_i  (hit(W_OSC)),
    .wr_aux_i  (hit(W_AUX)),
    .wdata_i,
    .lock_rd_o (lock_rd),
    .osc_o     (osc_q),
    .aux_o     (aux_q)
  );

  // set/clear flag words
  logic [DW-1:0] flag_q [NFLAG];
  widx_t         set_idx [NFLAG];
  assign set_idx[0] = W_FLG_SET;
  assign set_idx[1] = W_NVF_SET;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    cm_setclr_reg #(.WIDTH(DW)) u_flag (
      .clk_i, .rst_ni,
      .set_i  (hit(set_idx[g])),
      .clr_i  (hit(set_idx[g] + 6'd1)),
      .data_i (wdata_i),
      .q_o    (flag_q[g])
    );
  end

  logic [CNT_W-1:0] cnt_q;
  cm_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .cnt_o (cnt_q)
  );

  logic          level_q;
  logic [DW-1:0] irq_en_q, fiq_en_q;
  cm_irq_group u_irq (
    .clk_i, .rst_ni,
    .soft_set_i (hit(W_SOFT_SET)),
    .soft_clr_i (hit(W_SOFT_CLR)),
    .irq_ens_i  (hit(W_IRQ_ENS)),
    .irq_enc_i  (hit(W_IRQ_ENC)),
    .fiq_ens_i  (hit(W_FIQ_ENS)),
    .fiq_enc_i  (hit(W_FIQ_ENC)),
    .wdata_i,
    .level_o    (level_q),
    .irq_en_o   (irq_en_q),
    .fiq_en_o   (fiq_en_q),
    .irq_o,
    .fiq_o
  );

  // control, plain words, reset pulse
  logic [DW-1:0] ctrl_q, sdram_q, init_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      sdram_q     <= SDRAM_RST;
      init_q      <= INIT_RST;
      reset_req_o <= 1'b0;
    end else begin
      reset_req_o <= hit(W_CTRL) && wdata_i[CTRL_RST_BIT];
      if (hit(W_CTRL))  ctrl_q  <= wdata_i & CTRL_KEEP;
      if (hit(W_SDRAM)) sdram_q <= wdata_i;
      if (hit(W_INIT))  init_q  <= wdata_i;
    end
  end

  assign led_o   = ctrl_q[0];
  assign remap_o = ctrl_q[2];

  // read path
  logic [DW-1:0] rd_reg, rd_next;
  always_comb begin
    unique case (widx)
      W_ID:       rd_reg = ID_VAL;
      W_OSC:      rd_reg = osc_q;
      W_CTRL:     rd_reg = ctrl_q;
      W_STAT:     rd_reg = STAT_VAL;
      W_LOCK:     rd_reg = lock_rd;
      W_AUX:      rd_reg = aux_q;
      W_SDRAM:    rd_reg = sdram_q;
      W_INIT:     rd_reg = init_q;
      W_REFCNT:   rd_reg = DW'(cnt_q);
      W_FLG_SET:  rd_reg = flag_q[0];
      W_NVF_SET:  rd_reg = flag_q[1];
      W_IRQ_STAT: rd_reg = {31'd0, level_q & irq_en_q[0]};
      W_IRQ_RAW,
      W_FIQ_RAW,
      W_SOFT_SET: rd_reg = {31'd0, level_q};
      W_IRQ_ENS:  rd_reg = irq_en_q;
      W_FIQ_STAT: rd_reg = {31'd0, level_q & fiq_en_q[0]};
      W_FIQ_ENS:  rd_reg = fiq_en_q;
      default:    rd_reg = '0;
    endcase
  end

  always_comb begin
    if (in_regs)     rd_next = rd_reg;
    else if (win_lo) rd_next = {24'd0, desc_byte(addr_i[6:2], MEM_MB)};
    else             rd_next = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_next;
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o); // R5
  AST_RD_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R11
  AST_WR_NO_RV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R11
  AST_CTRL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit(W_CTRL) |=> (led_o == $past(wdata_i[0])) && (remap_o == $past(wdata_i[2]))); // R4
endmodule

// File: tb/tb_cm_sysctl_regs.sv
module tb_cm_sysctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid, led, remap, rst_req, irq, fiq;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cm_sysctl_regs #(.ADDR_W(AW), .MEM_MB(128), .CNT_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata),
    .led_o(led), .remap_o(remap), .reset_req_o(rst_req),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results arrive
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] e, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset led", {31'd0, led}, 0);
    check("R9 reset remap", {31'd0, remap}, 0);
    check("R5 reset pulse idle", {31'd0, rst_req}, 0);
    check("R10 reset irq", {31'd0, irq | fiq}, 0);
    check("R11 no rvalid idle", {31'd0, rvalid}, 0);

    rd(0*4, 32'h411A3001, "R1 id");
    rd(4*4, 32'h00100000, "R1 status");
    rd(1*4, 32'h0, "R1 proc");
    rd(6*4, 32'h0, "R1 undefined 6");
    rd(13*4, 32'h0, "R1 clear addr");
    rd(12*4 + 2, 32'h0, "R1 unaligned");
    rd(32'h200, 32'h0, "R1 above window");
    rd(2*4, 32'h01000048, "R9 osc reset");
    rd(7*4, 32'h0007FEFF, "R9 aux reset");
    rd(9*4, 32'h00000112, "R9 init reset");
    rd(8*4, 32'h0001112E, "R9 sdram size code");
    rd(5*4, 32'h0, "R9 lock reset");

    wr(2*4, 32'h11111111);
    rd(2*4, 32'h01000048, "R3 osc locked");
    wr(5*4, 32'h1234A05F);
    rd(5*4, 32'h0001A05F, "R2 lock key readback");
    wr(2*4, 32'hDEADBEEF);
    rd(2*4, 32'hDEADBEEF, "R3 osc unlocked");
    wr(7*4, 32'h00C0FFEE);
    rd(7*4, 32'h00C0FFEE, "R3 aux unlocked");
    wr(5*4, 32'hFFFF1234);
    rd(5*4, 32'h00001234, "R2 lock low half");
    wr(7*4, 32'h0);
    rd(7*4, 32'h00C0FFEE, "R3 aux relocked");

    wr(3*4, 32'hFFFFFFF7);
    rd(3*4, 32'h5, "R4 ctrl kept bits");
    check("R4 led on", {31'd0, led}, 1);
    check("R4 remap on", {31'd0, remap}, 1);
    check("R5 no pulse without bit3", {31'd0, rst_req}, 0);
    wr(3*4, 32'h0000000C);
    check("R5 pulse high", {31'd0, rst_req}, 1);
    check("R4 led off", {31'd0, led}, 0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, rst_req}, 0);
    rd(3*4, 32'h4, "R4 bit3 reads zero");

    wr(12*4, 32'h000000F0);
    wr(12*4, 32'h0000000F);
    rd(12*4, 32'h000000FF, "R6 flags set or");
    wr(13*4, 32'h0000003C);
    rd(12*4, 32'h000000C3, "R6 flags clear");
    wr(14*4, 32'h80000001);
    wr(15*4, 32'h00000001);
    rd(14*4, 32'h80000000, "R6 nvflags");
    rd(12*4, 32'h000000C3, "R6 flags independent");

    rd(10*4, 32'h0, "R7 counter idle");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    rd(10*4, 32'd5, "R7 counter ticks");
    wr(10*4, 32'h12345678);
    rd(10*4, 32'd5, "R7 counter write ignored");

    rd(32'h100, 32'h80, "R8 desc byte0");
    rd(32'h104, 32'h00, "R8 desc byte1");
    rd(32'h108, 32'h04, "R8 desc byte2");
    rd(32'h17C, 32'h20, "R8 desc density");
    rd(32'h180, 32'h00, "R8 upper half zero");
    rd(32'h1FC, 32'h00, "R8 window end zero");

    wr(8*4, 32'hA5A5A5A5);
    rd(8*4, 32'hA5A5A5A5, "R9 sdram write");
    wr(9*4, 32'h0000ABCD);
    rd(9*4, 32'h0000ABCD, "R9 init write");

    wr(18*4, 32'h00000003);
    rd(18*4, 32'h3, "R10 irq enable set");
    check("R10 irq idle with enable", {31'd0, irq}, 0);
    wr(20*4, 32'h00000003);
    rd(17*4, 32'h1, "R10 raw");
    rd(20*4, 32'h1, "R10 soft read");
    rd(16*4, 32'h1, "R10 irq status");
    rd(24*4, 32'h0, "R10 fiq status masked");
    check("R10 irq high", {31'd0, irq}, 1);
    check("R10 fiq low", {31'd0, fiq}, 0);
    wr(26*4, 32'h00000001);
    check("R10 fiq high", {31'd0, fiq}, 1);
    wr(19*4, 32'h00000001);
    rd(18*4, 32'h2, "R10 irq enable clear");
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(21*4, 32'h00000000);
    check("R10 soft clr needs bit0", {31'd0, fiq}, 1);
    wr(21*4, 32'h00000001);
    check("R10 fiq dropped", {31'd0, fiq}, 0);
    rd(25*4, 32'h0, "R10 raw cleared");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule